// File: doc/BRIEF.md
# Sensorless Sector Search Controller

This block tracks which 60-degree region of the plane the grid voltage vector occupies, although it never measures that voltage. It keeps a sector guess, hands it to an attached duty and dwell-time solver, and then judges the four numbers the solver returns. These are the two axis duty ratios and the two active-vector durations. If the trial is unusable, the guess moves to the following sector of a fixed eight-entry ring, and the solver runs again within the same switching period. A usable trial marks the controller as locked, releases the power-stage gates, and emits the accepted results.

The search begins on a one-cycle `period_start` strobe. Trials use a start/done handshake: `sol_start` is a one-cycle pulse that carries the sector on `sol_sector`, and the solver raises `sol_done` for one cycle when its results are ready. The controller always accepts `sol_done`, so the solver side has no back-pressure. Accepted results leave as a one-cycle `out_valid` pulse, again with no ready signal. The consumer must take them in that cycle. The sector that locked becomes the first guess of the next period.

Along with each sector the controller tells the solver which family of dwell-time equations applies and which current axes must be sign-flipped to make them non-negative.

Top module: `sector_seek`

## Requirements
- R1: During and after reset, and before any search, the sector code is 0, and `locked`, `fault`, `gate_en` and `out_valid` are all low.
- R2: The ring visits sector codes 0 through 7 in ascending order, meaning sectors 1, 2A, 2B, 3, 4, 5A, 5B, 6. After code 7 it wraps to code 0, and the code never changes in any other way.
- R3: A trial is accepted only when both duty ratios are strictly below one and the sum t1 + t2 does not exceed `period_len`. A duty ratio is unsigned with DUTY_FRAC fractional bits, so one is 1024 by default. Equal to one is rejected, and a sum equal to `period_len` is accepted.
- R4: A `period_start` seen while idle launches a trial with the held sector. Each rejected trial advances the sector by one ring step and launches a new trial in the same period, with one `sol_start` pulse per trial.
- R5: An accepted trial sets `locked`, pulses `out_valid` once, and outputs the sector and the four solver values of that trial. The sector is kept, so the next period starts its first trial there.
- R6: `gate_en` is high only while the controller is locked and not faulted. A rejected trial drops `locked` and `gate_en`.
- R7: At most MAX_TRIES (8) trials run per period. When all of them are rejected, `fault` goes high, `locked` and `gate_en` stay low, no `out_valid` occurs, and the sector is back at the code the period began with.
- R8: `sol_alt_set` is 0 for codes 0, 3, 4 and 7 and is 1 for codes 1, 2, 5 and 6.
- R9: `sol_alpha_neg` is 1 for codes 2 to 5, and `sol_beta_neg` is 1 for codes 4 to 7. Otherwise both are 0.
- R10: A `period_start` that arrives while a search is running has no effect: no extra trial is launched.
- R11: A later accepted trial clears `fault` and locks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | One-cycle strobe at the start of each switching period |
| period_len | input | TIME_W | Switching period length in time units |
| sol_start | output | 1 | One-cycle pulse that launches a solver trial |
| sol_sector | output | 3 | Current sector guess (codes 0-7) |
| sol_alt_set | output | 1 | Dwell-time equation family for the sector |
| sol_alpha_neg | output | 1 | Negate alpha current for rectification |
| sol_beta_neg | output | 1 | Negate beta current for rectification |
| sol_done | input | 1 | One-cycle pulse: solver results are valid |
| sol_duty_a | input | DUTY_W | Alpha-axis duty ratio from the solver |
| sol_duty_b | input | DUTY_W | Beta-axis duty ratio from the solver |
| sol_t1 | input | TIME_W | First active-vector duration |
| sol_t2 | input | TIME_W | Second active-vector duration |
| out_valid | output | 1 | One-cycle pulse: accepted results present |
| out_sector | output | 3 | Sector of the accepted trial |
| out_duty_a | output | DUTY_W | Accepted alpha duty ratio |
| out_duty_b | output | DUTY_W | Accepted beta duty ratio |
| out_t1 | output | TIME_W | Accepted first duration |
| out_t2 | output | TIME_W | Accepted second duration |
| locked | output | 1 | Controller has a valid sector |
| fault | output | 1 | No sector was valid in the last full ring |
| gate_en | output | 1 | Power-stage gates permitted |

## Verification
The assertions assume that the solver raises `sol_done` only while a trial is outstanding, exactly once per `sol_start`, and never in the same cycle as the start. The bench solver model enforces this. It watches for `sol_start`, waits a fixed latency, and then drives `sol_done` for one cycle. It reports a usable result only when the trial sector matches a chosen "true" sector, and it reports a duty ratio above one for every other sector. Boundary values for R3 are applied only at the matching sector, so a rejection can be seen as a complete, faulted ring search.

// File: rtl/sector_seek_pkg.sv
package sector_seek_pkg;
  localparam int SEC_W = 3;

  // ring order is behavioural: codes ascend through 1,2A,2B,3,4,5A,5B,6
  typedef enum logic [SEC_W-1:0] {
    SEC_1  = 3'd0,
    SEC_2A = 3'd1,
    SEC_2B = 3'd2,
    SEC_3  = 3'd3,
    SEC_4  = 3'd4,
    SEC_5A = 3'd5,
    SEC_5B = 3'd6,
    SEC_6  = 3'd7
  } sector_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seek_st_e;

  function automatic sector_e ring_next(sector_e s);
    return (s == SEC_6) ? SEC_1 : sector_e'(s + 3'd1);
  endfunction
endpackage

// File: rtl/sector_decode.sv
module sector_decode
  import sector_seek_pkg::*;
(
  input  sector_e sec,
  output sector_e sec_next,
  output logic    alt_set,
  output logic    alpha_neg,
  output logic    beta_neg
);
  always_comb begin
    sec_next  = ring_next(sec);
    alt_set   = 1'b0;
    alpha_neg = 1'b0;
    beta_neg  = 1'b0;
    unique case (sec)
      SEC_1:  begin alt_set = 1'b0; alpha_neg = 1'b0; beta_neg = 1'b0; end
      SEC_2A: begin alt_set = 1'b1; alpha_neg = 1'b0; beta_neg = 1'b0; end
      SEC_2B: begin alt_set = 1'b1; alpha_neg = 1'b1; beta_neg = 1'b0; end
      SEC_3:  begin alt_set = 1'b0; alpha_neg = 1'b1; beta_neg = 1'b0; end
      SEC_4:  begin alt_set = 1'b0; alpha_neg = 1'b1; beta_neg = 1'b1; end
      SEC_5A: begin alt_set = 1'b1; alpha_neg = 1'b1; beta_neg = 1'b1; end
      SEC_5B: begin alt_set = 1'b1; alpha_neg = 1'b0; beta_neg = 1'b1; end
      SEC_6:  begin alt_set = 1'b0; alpha_neg = 1'b0; beta_neg = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/trial_judge.sv
module trial_judge #(
  parameter int DUTY_W    = 12,
  parameter int DUTY_FRAC = 10,
  parameter int TIME_W    = 12
) (
  input  logic [DUTY_W-1:0] duty_a,
  input  logic [DUTY_W-1:0] duty_b,
  input  logic [TIME_W-1:0] t1,
  input  logic [TIME_W-1:0] t2,
  input  logic [TIME_W-1:0] period_len,
  output logic              ok
);
  localparam logic [DUTY_W-1:0] DUTY_ONE = DUTY_W'(1) << DUTY_FRAC;

  logic [TIME_W:0] dwell_sum;
  logic            duty_ok;
  logic            time_ok;

  always_comb begin
    dwell_sum = {1'b0, t1} + {1'b0, t2};
    duty_ok   = (duty_a < DUTY_ONE) && (duty_b < DUTY_ONE);
    time_ok   = dwell_sum <= {1'b0, period_len};
    ok        = duty_ok && time_ok;
  end
endmodule

// File: rtl/sector_seek.sv
module sector_seek
  import sector_seek_pkg::*;
#(
  parameter int DUTY_W    = 12,
  parameter int DUTY_FRAC = 10,
  parameter int TIME_W    = 12,
  parameter int MAX_TRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_start,
  input  logic [TIME_W-1:0] period_len,
  output logic              sol_start,
  output logic [2:0]        sol_sector,
  output logic              sol_alt_set,
  output logic              sol_alpha_neg,
  output logic              sol_beta_neg,
  input  logic              sol_done,
  input  logic [DUTY_W-1:0] sol_duty_a,
  input  logic [DUTY_W-1:0] sol_duty_b,
  input  logic [TIME_W-1:0] sol_t1,
  input  logic [TIME_W-1:0] sol_t2,
  output logic              out_valid,
  output logic [2:0]        out_sector,
  output logic [DUTY_W-1:0] out_duty_a,
  output logic [DUTY_W-1:0] out_duty_b,
  output logic [TIME_W-1:0] out_t1,
  output logic [TIME_W-1:0] out_t2,
  output logic              locked,
  output logic              fault,
  output logic              gate_en
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

  seek_st_e         st;
  sector_e          sector;
  sector_e          sector_nxt;
  logic [TRY_W-1:0] tries;
  logic             trial_ok;

  sector_decode u_decode (
    .sec       (sector),
    .sec_next  (sector_nxt),
    .alt_set   (sol_alt_set),
    .alpha_neg (sol_alpha_neg),
    .beta_neg  (sol_beta_neg)
  );

  trial_judge #(
    .DUTY_W    (DUTY_W),
    .DUTY_FRAC (DUTY_FRAC),
    .TIME_W    (TIME_W)
  ) u_judge (
    .duty_a     (sol_duty_a),
    .duty_b     (sol_duty_b),
    .t1         (sol_t1),
    .t2         (sol_t2),
    .period_len (period_len),
    .ok         (trial_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sector     <= SEC_1;
      tries      <= '0;
      locked     <= 1'b0;
      fault      <= 1'b0;
      out_valid  <= 1'b0;
      out_sector <= '0;
      out_duty_a <= '0;
      out_duty_b <= '0;
      out_t1     <= '0;
      out_t2     <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (period_start) begin
            tries <= '0;
            st    <= ST_ISSUE;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (sol_done) begin
            if (trial_ok) begin
              locked     <= 1'b1;
              fault      <= 1'b0;
              out_valid  <= 1'b1;
              out_sector <= sector;
              out_duty_a <= sol_duty_a;
              out_duty_b <= sol_duty_b;
              out_t1     <= sol_t1;
              out_t2     <= sol_t2;
              st         <= ST_IDLE;
            end else begin
              locked <= 1'b0;
              sector <= sector_nxt;
              if (tries == LAST_TRY) begin
                fault <= 1'b1;
                st    <= ST_IDLE;
              end else begin
                tries <= tries + 1'b1;
                st    <= ST_ISSUE;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sol_start  = (st == ST_ISSUE);
  assign sol_sector = sector;
  assign gate_en    = locked && !fault;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sol_start |=> !sol_start); // R4
  AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sol_sector != $past(sol_sector)) |-> (sol_sector == 3'(ring_next(sector_e'($past(sol_sector)))))); // R2
  AST_STEP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sol_sector != $past(sol_sector)) |-> $past(sol_done)); // R4
  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= LAST_TRY); // R7
  AST_GATE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> ($past(sol_done) && out_valid)); // R6
  AST_FAULT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ($past(sol_done) && !gate_en && !out_valid)); // R7
  AST_OUT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (locked && !fault && out_sector == sol_sector)); // R5
endmodule

// File: tb/sector_seek_tb.sv
module sector_seek_tb;
  localparam int DUTY_W = 12;
  localparam int TIME_W = 12;
  localparam int ONE    = 1024;
  localparam int LAT    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              period_start = 1'b0;
  logic [TIME_W-1:0] period_len = 12'd1000;
  logic              sol_start;
  logic [2:0]        sol_sector;
  logic              sol_alt_set, sol_alpha_neg, sol_beta_neg;
  logic              sol_done = 1'b0;
  logic [DUTY_W-1:0] sol_duty_a = '0, sol_duty_b = '0;
  logic [TIME_W-1:0] sol_t1 = '0, sol_t2 = '0;
  logic              out_valid;
  logic [2:0]        out_sector;
  logic [DUTY_W-1:0] out_duty_a, out_duty_b;
  logic [TIME_W-1:0] out_t1, out_t2;
  logic              locked, fault, gate_en;

  sector_seek u_dut (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .period_len(period_len),
    .sol_start(sol_start), .sol_sector(sol_sector), .sol_alt_set(sol_alt_set),
    .sol_alpha_neg(sol_alpha_neg), .sol_beta_neg(sol_beta_neg),
    .sol_done(sol_done), .sol_duty_a(sol_duty_a), .sol_duty_b(sol_duty_b),
    .sol_t1(sol_t1), .sol_t2(sol_t2),
    .out_valid(out_valid), .out_sector(out_sector), .out_duty_a(out_duty_a),
    .out_duty_b(out_duty_b), .out_t1(out_t1), .out_t2(out_t2),
    .locked(locked), .fault(fault), .gate_en(gate_en)
  );

  always #5 clk = ~clk;

  int errs = 0;
  int checks = 0;
  int true_sec = 0;
  int m_da = 512, m_db = 300, m_t1 = 400, m_t2 = 500;
  int n_starts = 0;
  int n_valid = 0;
  int trace[0:15];
  int cap_sec, cap_da, cap_db, cap_t1, cap_t2;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // solver model: one result LAT cycles after each start
  initial begin
    forever begin
      @(negedge clk);
      sol_done = 1'b0;
      if (sol_start) begin
        if (n_starts < 16) trace[n_starts] = int'(sol_sector);
        n_starts++;
        repeat (LAT) @(negedge clk);
        if (int'(sol_sector) == true_sec) begin
          sol_duty_a = DUTY_W'(m_da); sol_duty_b = DUTY_W'(m_db);
          sol_t1 = TIME_W'(m_t1);     sol_t2 = TIME_W'(m_t2);
        end else begin
          sol_duty_a = DUTY_W'(ONE + 5); sol_duty_b = '0;
          sol_t1 = '0; sol_t2 = '0;
        end
        sol_done = 1'b1;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        n_valid++;
        cap_sec = int'(out_sector); cap_da = int'(out_duty_a); cap_db = int'(out_duty_b);
        cap_t1 = int'(out_t1); cap_t2 = int'(out_t2);
      end
    end
  end

  task automatic run_period(int tsec);
    true_sec = tsec;
    n_starts = 0;
    n_valid  = 0;
    @(negedge clk); period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 sector", int'(sol_sector), 0);
    check("R1 locked", int'(locked), 0);
    check("R1 fault", int'(fault), 0);
    check("R1 gate_en", int'(gate_en), 0);
    check("R1 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sector after release", int'(sol_sector), 0);
    check("R1 no start without strobe", int'(sol_start), 0);
  endtask

  task automatic t_search();
    run_period(3);
    check("R4 trials 0->3", n_starts, 4);
    for (int i = 0; i < 4; i++) check("R2 order 0->3", trace[i], i);
    run_period(6);
    check("R4 trials 3->5B", n_starts, 4);
    check("R2 trace 4", trace[1], 4);
    check("R2 trace 5A", trace[2], 5);
    check("R5 locked", int'(locked), 1);
    check("R5 one out_valid", n_valid, 1);
    check("R5 out_sector", cap_sec, 6);
    check("R5 out_duty_a", cap_da, m_da);
    check("R5 out_duty_b", cap_db, m_db);
    check("R5 out_t1", cap_t1, m_t1);
    check("R5 out_t2", cap_t2, m_t2);
    check("R6 gate on when locked", int'(gate_en), 1);
  endtask

  task automatic t_hold_and_wrap();
    run_period(6);
    check("R5 held sector one trial", n_starts, 1);
    check("R5 first guess", trace[0], 6);
    run_period(7);
    check("R4 advance one", n_starts, 2);
    run_period(0);
    check("R2 wrap trials", n_starts, 2);
    check("R2 wrap from 7", trace[0], 7);
    check("R2 wrap to 0", trace[1], 0);
    check("R2 wrap sector", int'(sol_sector), 0);
  endtask

  task automatic t_fault();
    run_period(99);
    check("R7 eight trials", n_starts, 8);
    check("R7 fault", int'(fault), 1);
    check("R7 locked low", int'(locked), 0);
    check("R6 gate off on fault", int'(gate_en), 0);
    check("R7 no out_valid", n_valid, 0);
    check("R7 sector restored", int'(sol_sector), 0);
    run_period(2);
    check("R11 fault cleared", int'(fault), 0);
    check("R11 relocked", int'(locked), 1);
    check("R11 gate back", int'(gate_en), 1);
    check("R11 out_sector", cap_sec, 2);
  endtask

  task automatic t_bounds();
    m_da = ONE - 1; m_db = ONE - 1; m_t1 = 600; m_t2 = 400;
    run_period(2);
    check("R3 edge accepted trials", n_starts, 1);
    check("R3 edge accepted lock", int'(locked), 1);
    m_da = ONE;
    run_period(2);
    check("R3 duty_a one rejected", int'(fault), 1);
    check("R3 duty_a trials", n_starts, 8);
    m_da = 100; m_db = ONE;
    run_period(2);
    check("R3 duty_b one rejected", int'(fault), 1);
    m_db = 100; m_t2 = 401;
    run_period(2);
    check("R3 sum over period rejected", int'(fault), 1);
    check("R6 gate off after reject", int'(gate_en), 0);
    m_da = 512; m_db = 300; m_t1 = 400; m_t2 = 500;
    run_period(2);
    check("R3 restore lock", int'(locked), 1);
  endtask

  task automatic t_double_strobe();
    true_sec = 5;
    n_starts = 0;
    n_valid  = 0;
    @(negedge clk); period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    repeat (3) @(negedge clk);
    period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
    repeat (80) @(negedge clk);
    check("R10 strobe during search ignored", n_starts, 4);
    check("R10 single result", n_valid, 1);
  endtask

  task automatic t_decode_walk();
    for (int k = 0; k < 8; k++) begin
      run_period(k);
      check("R2 walk sector", int'(sol_sector), k);
      check("R8 alt set", int'(sol_alt_set), (k == 1 || k == 2 || k == 5 || k == 6) ? 1 : 0);
      check("R9 alpha neg", int'(sol_alpha_neg), (k >= 2 && k <= 5) ? 1 : 0);
      check("R9 beta neg", int'(sol_beta_neg), (k >= 4) ? 1 : 0);
    end
  endtask

  initial begin
    #1000000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_search();
    t_hold_and_wrap();
    t_fault();
    t_bounds();
    t_double_strobe();
    t_decode_walk();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule